// File: doc/BRIEF.md
# Buck Converter Fault Supervisor and Start-Up Sequencer

This block decides when the power stage of a step-down converter may switch. It sees a strobe that marks the end of each converter switching period, together with the overcurrent and overvoltage comparator results captured at that moment. It also sees the external enable and the supply-good flag from the undervoltage monitor. From these it drives the power-stage enable, a flag that shows soft start is in progress, and a ramp code for the reference DAC.

Overcurrent is judged by duty rather than by single events. A small score rises by two on every period that ends in overcurrent and falls by one on every clean period. When the score saturates, the stage is turned off for a fixed number of periods and then brought back up through a fresh soft start. A long unbroken run of overvoltage periods shuts the stage down for good. Only removing the enable or the supply releases that state.

Top module: `conv_fault_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `stage_en`, `ss_active` and `ss_ramp` are all zero.
- R2: On the first clock edge that finds `en` and `vin_ok` both high while the block is off, soft start begins: `stage_en` and `ss_active` go to 1 and `ss_ramp` is 0.
- R3: The overcurrent score is 4 bits and starts at 0. It changes only on a tick while the stage is enabled: +2 if `oc_flag` is high, otherwise -1. A decrement at 0 leaves it at 0. A pattern of one fault tick in three never trips. A pattern of one fault tick in two does trip.
- R4: An increment from 14 gives 15, with no wrap. On the tick where the score reaches 15, `stage_en` and `ss_active` drop to 0 and `ss_ramp` to 0.
- R5: After an overcurrent shutdown, the stage stays off for 16 ticks. On the 16th tick it restarts soft start with `ss_ramp` = 0 and the score cleared.
- R6: Soft start lasts exactly 4096 ticks. On the 4096th tick `ss_active` falls, `stage_en` stays 1 and `ss_ramp` becomes all ones.
- R7: During soft start, `ss_ramp` equals the upper 8 bits of the 12-bit tick count since soft start began, so it never decreases.
- R8: The overvoltage run count goes back to zero on any tick without `ov_flag`.
- R9: On the 32nd consecutive tick with `ov_flag` while enabled, the stage turns off. It then stays off whatever the tick and flag inputs do.
- R10: The overvoltage shutdown is left only when `en` or `vin_ok` goes low. Once both are high again, soft start begins afresh.
- R11: With `en` or `vin_ok` low at a clock edge, the stage is off after that edge and all sequencing state is cleared.
- R12: On clocks with `tick` low, `oc_flag` and `ov_flag` have no effect, and neither the ramp nor the counters advance.
- R13: When one tick completes both an overvoltage run and an overcurrent saturation, the overvoltage shutdown wins and no automatic restart follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable request |
| vin_ok | input | 1 | Input supply above its lockout level |
| tick | input | 1 | One-clock strobe at the end of each switching period |
| oc_flag | input | 1 | Overcurrent comparator result for the period ending now |
| ov_flag | input | 1 | Overvoltage comparator result for the period ending now |
| stage_en | output | 1 | Power stage may switch |
| ss_active | output | 1 | Soft start in progress |
| ss_ramp | output | RAMP_W | Reference ramp code |

## Verification
The bench drives the score to its floor with long clean stretches and then counts exactly how many fault ticks it takes to trip. A design that wrapped below zero would trip at once, and one that wrapped above 14 would never trip. It breaks an overvoltage run one tick short of the limit to catch a count that is not cleared on a clean tick. It also raises both faults on the same tick to catch a design that lets the overcurrent path restart out of a latched overvoltage. Hold-off and soft-start lengths are checked to the exact tick, so an off-by-one counter restarts one period early or late. Flags held high on non-tick clocks catch a design that samples the comparators every clock.

// File: rtl/conv_fault_pkg.sv
package conv_fault_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LATCH = 3'd4
  } seq_state_t;
endpackage

// File: rtl/oc_score.sv
// Leaky overcurrent score: +UP_STEP on a fault tick, -1 on a clean tick,
// clamped to [0, all ones].
module oc_score #(
  parameter int W       = 4,
  parameter int UP_STEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         fault,
  output logic         trip,
  output logic [W-1:0] score
);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] UP   = W'(UP_STEP);
  localparam logic [W-1:0] ROOM = TOP - UP;

  logic [W-1:0] score_nxt;

  always_comb begin
    if (fault) begin
      score_nxt = (score > ROOM) ? TOP : score + UP;
    end else begin
      score_nxt = (score == '0) ? '0 : score - W'(1);
    end
  end

  assign trip = step && (score_nxt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      score <= '0;
    end else if (step) begin
      score <= score_nxt;
    end
  end
endmodule

// File: rtl/ov_watch.sv
// Counts consecutive overvoltage ticks; any clean tick restarts the run.
module ov_watch #(
  parameter int RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic ov,
  output logic trip
);
  localparam int          CW   = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIM  = CW'(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_cnt;

  assign trip = step && ov && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_cnt <= '0;
    end else if (step) begin
      if (!ov) begin
        run_cnt <= '0;
      end else if (run_cnt != LIM) begin
        run_cnt <= run_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/ss_counter.sv
// Soft-start period counter; done pulses on the tick that ends the ramp.
module ss_counter #(
  parameter int SS_W   = 12,
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic              done,
  output logic [RAMP_W-1:0] ramp
);
  logic [SS_W-1:0] cnt;

  assign done = step && (cnt == {SS_W{1'b1}});
  assign ramp = cnt[SS_W-1 -: RAMP_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + SS_W'(1);
    end
  end
endmodule

// File: rtl/conv_fault_seq.sv
module conv_fault_seq #(
  parameter int SCORE_W    = 4,
  parameter int OC_UP      = 2,
  parameter int OV_RUN     = 32,
  parameter int HOLD_TICKS = 16,
  parameter int SS_W       = 12,
  parameter int RAMP_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              vin_ok,
  input  logic              tick,
  input  logic              oc_flag,
  input  logic              ov_flag,
  output logic              stage_en,
  output logic              ss_active,
  output logic [RAMP_W-1:0] ss_ramp
);
  import conv_fault_pkg::*;

  localparam int            HW        = $clog2(HOLD_TICKS);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  seq_state_t    state;
  logic [HW-1:0] hold_cnt;
  logic          go, live, start, clr_all;
  logic          oc_trip, ov_trip, ss_done;
  logic [SCORE_W-1:0] score;
  logic [RAMP_W-1:0]  ramp_cnt;

  assign go      = en && vin_ok;
  assign live    = (state == ST_SOFT) || (state == ST_RUN);
  assign start   = go && ((state == ST_OFF) ||
                          ((state == ST_HOLD) && tick && (hold_cnt == HOLD_LAST)));
  assign clr_all = !go || start;

  oc_score #(.W(SCORE_W), .UP_STEP(OC_UP)) u_oc (
    .clk(clk), .rst(rst), .clr(clr_all), .step(tick && live),
    .fault(oc_flag), .trip(oc_trip), .score(score)
  );

  ov_watch #(.RUN_LEN(OV_RUN)) u_ov (
    .clk(clk), .rst(rst), .clr(clr_all), .step(tick && live),
    .ov(ov_flag), .trip(ov_trip)
  );

  ss_counter #(.SS_W(SS_W), .RAMP_W(RAMP_W)) u_ss (
    .clk(clk), .rst(rst), .clr(clr_all || oc_trip || ov_trip),
    .step(tick && (state == ST_SOFT)), .done(ss_done), .ramp(ramp_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      state    <= ST_OFF;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_OFF: state <= ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (ov_trip) begin
            state <= ST_LATCH;
          end else if (oc_trip) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
          end else if (ss_done) begin
            state <= ST_RUN;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (hold_cnt == HOLD_LAST) begin
              state <= ST_SOFT;
            end else begin
              hold_cnt <= hold_cnt + HW'(1);
            end
          end
        end
        ST_LATCH: state <= ST_LATCH;
        default:  state <= ST_OFF;
      endcase
    end
  end

  assign stage_en  = live;
  assign ss_active = (state == ST_SOFT);
  assign ss_ramp   = (state == ST_RUN)  ? {RAMP_W{1'b1}} :
                     (state == ST_SOFT) ? ramp_cnt : '0;
endmodule

// File: rtl/conv_fault_seq_chk.sv
module conv_fault_seq_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              vin_ok,
  input logic              tick,
  input logic              stage_en,
  input logic              ss_active,
  input logic [RAMP_W-1:0] ss_ramp,
  input logic [2:0]        st
);
  import conv_fault_pkg::*;

  // R2: start from off enters soft start at ramp zero
  a_r2_start_soft: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF && en && vin_ok) |=> (stage_en && ss_active && ss_ramp == '0));

  // R7: ramp never falls during one soft start
  a_r7_ramp_rises: assert property (@(posedge clk) disable iff (rst)
    (ss_active && $past(ss_active)) |-> (ss_ramp >= $past(ss_ramp)));

  // R9: latched overvoltage holds while enable and supply stay good
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && en && vin_ok) |=> (st == ST_LATCH && !stage_en));

  // R11: enable or supply low forces the stage off
  a_r11_force_off: assert property (@(posedge clk) disable iff (rst)
    (!en || !vin_ok) |=> (!stage_en && !ss_active && ss_ramp == '0));

  // R12: nothing advances without a tick
  a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && en && vin_ok) |=> $stable(ss_ramp));
endmodule

bind conv_fault_seq conv_fault_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .vin_ok(vin_ok), .tick(tick),
  .stage_en(stage_en), .ss_active(ss_active), .ss_ramp(ss_ramp),
  .st(state)
);

// File: tb/test_conv_fault_seq.sv
`timescale 1ns/1ps
module test_conv_fault_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, vin_ok = 1'b0, tick = 1'b0, oc_flag = 1'b0, ov_flag = 1'b0;
  logic       stage_en, ss_active;
  logic [7:0] ss_ramp;

  always #4 clk = ~clk;

  conv_fault_seq i_conv_fault_seq (
    .clk(clk), .rst(rst), .en(en), .vin_ok(vin_ok), .tick(tick),
    .oc_flag(oc_flag), .ov_flag(ov_flag),
    .stage_en(stage_en), .ss_active(ss_active), .ss_ramp(ss_ramp)
  );

  int total = 0, bad = 0, clocks = 0;
  string cur_req = "R1";

  // Behavioural reference: 0 off, 1 soft, 2 run, 3 hold-off, 4 latched
  int m_st = 0, m_oc = 0, m_ov = 0, m_ss = 0, m_hold = 0;
  bit started = 1'b0;

  always @(posedge clk) begin
    started = 1'b1;
    clocks++;
    if (rst || !(en && vin_ok)) begin
      m_st = 0; m_oc = 0; m_ov = 0; m_ss = 0; m_hold = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_oc = 0; m_ov = 0; m_ss = 0;
    end else if (tick && (m_st == 1 || m_st == 2)) begin
      m_oc = oc_flag ? ((m_oc + 2 > 15) ? 15 : m_oc + 2) : ((m_oc == 0) ? 0 : m_oc - 1);
      m_ov = ov_flag ? m_ov + 1 : 0;
      if (m_ov >= 32) m_st = 4;
      else if (m_oc == 15) begin m_st = 3; m_hold = 0; m_ss = 0; end
      else if (m_st == 1) begin
        if (m_ss == 4095) m_st = 2; else m_ss++;
      end
    end else if (tick && m_st == 3) begin
      if (m_hold == 15) begin m_st = 1; m_oc = 0; m_ov = 0; m_ss = 0; end
      else m_hold++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "stage_en", int'(stage_en), (m_st == 1 || m_st == 2) ? 1 : 0);
      chk(cur_req, "ss_active", int'(ss_active), (m_st == 1) ? 1 : 0);
      chk(cur_req, "ss_ramp", int'(ss_ramp), (m_st == 1) ? (m_ss >> 4) : (m_st == 2) ? 255 : 0);
    end
  end

  // one clock: drive after the falling edge, return after the next one
  task automatic cyc(bit tk, bit oc, bit ov);
    #1;
    tick = tk; oc_flag = oc; ov_flag = ov;
    @(negedge clk);
  endtask

  task automatic ticks(int n, bit oc, bit ov);
    for (int i = 0; i < n; i++) cyc(1'b1, oc, ov);
  endtask

  initial begin
    @(negedge clk);
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R1", "stage_en in reset", int'(stage_en), 0);
    chk("R1", "ss_ramp in reset", int'(ss_ramp), 0);
    #1 rst = 1'b0; en = 1'b1; vin_ok = 1'b1;
    cur_req = "R2";
    @(negedge clk);
    chk("R2", "soft start entered", int'(stage_en && ss_active), 1);
    chk("R2", "ramp at start", int'(ss_ramp), 0);

    cur_req = "R12";
    for (int i = 0; i < 20; i++) cyc(0, 1, 1);
    chk("R12", "flags without tick ignored", int'(stage_en && ss_active && ss_ramp == 0), 1);

    cur_req = "R7";
    ticks(4095, 0, 0);
    chk("R7", "ramp one tick before end", int'(ss_ramp), 255);
    chk("R6", "still soft at tick 4095", int'(ss_active), 1);
    cur_req = "R6";
    ticks(1, 0, 0);
    chk("R6", "soft start over after 4096", int'(!ss_active && stage_en), 1);

    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin ticks(1, 1, 0); ticks(2, 0, 0); end
    chk("R3", "one in three never trips", int'(stage_en), 1);
    ticks(30, 0, 0);
    ticks(7, 1, 0);
    chk("R3", "score floored, 7 faults no trip", int'(stage_en), 1);
    cur_req = "R4";
    ticks(1, 1, 0);
    chk("R4", "trip on reaching 15", int'(stage_en), 0);

    cur_req = "R5";
    ticks(15, 0, 0);
    chk("R5", "still off after 15 ticks", int'(stage_en), 0);
    ticks(1, 0, 0);
    chk("R5", "restart on 16th tick", int'(stage_en && ss_active && ss_ramp == 0), 1);
    ticks(7, 1, 0);
    chk("R5", "score cleared at restart", int'(stage_en), 1);
    ticks(20, 0, 0);

    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin cyc(1, 1, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); end
    chk("R3", "one in two trips", int'(stage_en), 0);
    ticks(10, 0, 0);
    chk("R5", "back on after hold-off", int'(stage_en), 1);

    cur_req = "R8";
    ticks(31, 0, 1); ticks(1, 0, 0); ticks(31, 0, 1);
    chk("R8", "broken run does not trip", int'(stage_en), 1);
    cur_req = "R9";
    ticks(1, 0, 1);
    chk("R9", "trip on 32nd ov tick", int'(stage_en), 0);
    ticks(40, 0, 0);
    chk("R9", "latched off", int'(stage_en), 0);

    cur_req = "R10";
    #1 en = 1'b0; @(negedge clk);
    #1 en = 1'b1; @(negedge clk);
    chk("R10", "enable toggle restarts", int'(stage_en && ss_active), 1);

    cur_req = "R13";
    ticks(24, 0, 1); ticks(7, 1, 1); ticks(1, 1, 1);
    chk("R13", "joint trip turns off", int'(stage_en), 0);
    ticks(20, 0, 0);
    chk("R13", "ov wins, no auto restart", int'(stage_en), 0);

    cur_req = "R10";
    #1 vin_ok = 1'b0; @(negedge clk);
    chk("R11", "supply low keeps off", int'(stage_en), 0);
    #1 vin_ok = 1'b1; @(negedge clk);
    chk("R10", "supply toggle restarts", int'(stage_en && ss_active), 1);

    cur_req = "R11";
    ticks(100, 0, 0);
    #1 en = 1'b0; @(negedge clk);
    chk("R11", "enable low forces off", int'(stage_en || ss_active || ss_ramp != 0), 0);
    #1 en = 1'b1; @(negedge clk);
    chk("R11", "state cleared, ramp restarts at 0", int'(ss_ramp), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (clocks > 100000);
    total++; bad++;
    $display("FAIL watchdog: got %0d clocks expected under 100000", clocks);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule